// File: doc/BRIEF.md
# Batched Instruction Counter Bank

This block holds five 32-bit performance counters, numbered 1 to 5, that track retired instructions. Retirement is reported in batches: on any cycle the core may present a count of up to 255 instructions together with a valid strobe. Every counter selected by the enable mask then adds the whole batch in one update.

A counter whose new value has bit 31 set is pinned to exactly 0x80000000 when its overflow enable is on. A one-cycle overflow pulse follows any update in which at least one counter was pinned. Counter 1 has its own overflow enable, and counters 2 to 5 share a second one. Counter 4 is further gated: it only advances when an 8-bit event code taken from its select register equals 0x02, or when the run-latch input is high. Software can load any counter directly. A load takes precedence over a batch arriving on the same cycle.

Top module: `pmc_batch_bank`

## Requirements
- R1: While rst_ni is low, all five counters read 0 and ovf_o is 0.
- R2: Counter k (k = 1..5) advances on a batch only when en_mask_i[k] is 1; en_mask_i[0] has no effect on any counter.
- R3: On a cycle with batch_vld_i high, each counter allowed to count becomes old value plus batch_cnt_i (modulo 2^32) at that clock edge, in one step; with batch_vld_i low and no load, no counter changes.
- R4: If the new 32-bit value of a counting counter has bit 31 set and that counter's overflow enable is 1, the counter takes exactly 0x80000000.
- R5: Counter 1 uses ovf_en_c1_i as its overflow enable; counters 2, 3, 4 and 5 all use ovf_en_cx_i.
- R6: With its overflow enable at 0, a counter stores the sum unchanged, including values with bit 31 set and a wrap past 0xFFFFFFFF.
- R7: Counter 4 counts only if evt_sel4_i[15:8] equals 8'h02 or run_latch_i is 1; otherwise it holds. No other bits of evt_sel4_i matter.
- R8: ovf_o is 1 for exactly the one cycle after an update in which any counter was pinned per R4, and 0 otherwise.
- R9: When wr_en_i[k] is 1 (k = 1..5), counter k takes wr_data_i at the clock edge, skips that cycle's batch, and does not contribute to ovf_o. wr_en_i[0] has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_mask_i | input | 6 | Counting enable; bit k enables counter k, bit 0 unused |
| batch_vld_i | input | 1 | Batch present this cycle |
| batch_cnt_i | input | 8 | Number of instructions in the batch |
| ovf_en_c1_i | input | 1 | Overflow enable for counter 1 |
| ovf_en_cx_i | input | 1 | Overflow enable shared by counters 2 to 5 |
| evt_sel4_i | input | 32 | Counter 4 select register; event code in bits 15:8 |
| run_latch_i | input | 1 | Run-latch state |
| wr_en_i | input | 6 | Software load strobe; bit k loads counter k, bit 0 unused |
| wr_data_i | input | 32 | Value loaded by a software write |
| cnt_o | output | 160 | Counter values; counter k at bits 32k-1 down to 32(k-1) |
| ovf_o | output | 1 | One-cycle overflow pulse |

## Verification
All 64 values of the enable mask are swept with a different batch size each time. This separates a wrong mask bit, a use of bit 0 and a per-step increment from a whole-batch add. The counter 4 gate is swept over eight event codes against both run-latch levels, with 0x02 also planted in the byte below the field to catch a misplaced field. Counters are preloaded just under the threshold and bumped by batches below, at and past it under all four overflow-enable combinations, which separates the two enables, exact pinning and the pulse length. A wrap past 0xFFFFFFFF and loads that collide with batches cover unclamped storage and load priority.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_ADD  = 2'd1,
    ACT_LOAD = 2'd2
  } slot_act_e;
endpackage

// File: rtl/pmc_gate.sv
module pmc_gate #(
  parameter int unsigned               SEL_W     = 32,
  parameter int unsigned               EVT_LSB   = 8,
  parameter int unsigned               EVT_W     = 8,
  parameter logic [EVT_W-1:0]          FREE_CODE = 'h02
) (
  input  logic [SEL_W-1:0] evt_sel_i,
  input  logic             run_latch_i,
  output logic             allow_o
);
  logic [EVT_W-1:0] evt_code;
  logic             unused_sel;

  assign evt_code   = evt_sel_i[EVT_LSB +: EVT_W];
  assign allow_o    = (evt_code == FREE_CODE) || run_latch_i;
  assign unused_sel = ^evt_sel_i;
endmodule

// File: rtl/pmc_slot.sv
module pmc_slot
  import pmc_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned BATCH_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  slot_act_e          act_i,
  input  logic [BATCH_W-1:0] batch_i,
  input  logic               ovf_en_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               clamp_o
);
  localparam logic [CNT_W-1:0] THRESH = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] cnt_q, cnt_d, sum;

  assign sum     = cnt_q + CNT_W'(batch_i);
  assign clamp_o = (act_i == ACT_ADD) && sum[CNT_W-1] && ovf_en_i;

  always_comb begin
    unique case (act_i)
      ACT_LOAD: cnt_d = wr_data_i;
      ACT_ADD:  cnt_d = clamp_o ? THRESH : sum;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pmc_batch_bank.sv
module pmc_batch_bank
  import pmc_pkg::*;
#(
  parameter int unsigned NUM_CNT   = 5,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned BATCH_W   = 8,
  parameter int unsigned SEL_W     = 32,
  parameter int unsigned EVT_LSB   = 8,
  parameter int unsigned EVT_W     = 8,
  parameter int unsigned GATED_IDX = 4,
  localparam int unsigned MASK_W   = NUM_CNT + 1,
  localparam int unsigned OUT_W    = NUM_CNT * CNT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MASK_W-1:0]  en_mask_i,
  input  logic               batch_vld_i,
  input  logic [BATCH_W-1:0] batch_cnt_i,
  input  logic               ovf_en_c1_i,
  input  logic               ovf_en_cx_i,
  input  logic [SEL_W-1:0]   evt_sel4_i,
  input  logic               run_latch_i,
  input  logic [MASK_W-1:0]  wr_en_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  output logic [OUT_W-1:0]   cnt_o,
  output logic               ovf_o
);
  logic               gate_ok;
  logic [NUM_CNT:1]   clamp_vec;
  logic               ovf_q;
  logic               unused_bit0;

  assign unused_bit0 = en_mask_i[0] ^ wr_en_i[0];

  pmc_gate #(
    .SEL_W     (SEL_W),
    .EVT_LSB   (EVT_LSB),
    .EVT_W     (EVT_W),
    .FREE_CODE (EVT_W'('h02))
  ) u_gate (
    .evt_sel_i   (evt_sel4_i),
    .run_latch_i (run_latch_i),
    .allow_o     (gate_ok)
  );

  for (genvar i = 1; i <= NUM_CNT; i++) begin : g_slot
    localparam bit IS_GATED = (i == GATED_IDX);
    localparam bit OWN_OVF  = (i == 1);
    logic      allow;
    logic      ovf_en;
    slot_act_e act;

    assign allow  = IS_GATED ? gate_ok : 1'b1;
    assign ovf_en = OWN_OVF ? ovf_en_c1_i : ovf_en_cx_i;

    // software load wins over a same-cycle batch
    always_comb begin
      if (wr_en_i[i])                                 act = ACT_LOAD;
      else if (batch_vld_i && en_mask_i[i] && allow)  act = ACT_ADD;
      else                                            act = ACT_HOLD;
    end

    pmc_slot #(
      .CNT_W   (CNT_W),
      .BATCH_W (BATCH_W)
    ) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .act_i     (act),
      .batch_i   (batch_cnt_i),
      .ovf_en_i  (ovf_en),
      .wr_data_i (wr_data_i),
      .cnt_o     (cnt_o[(i-1)*CNT_W +: CNT_W]),
      .clamp_o   (clamp_vec[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= |clamp_vec;
  end

  assign ovf_o = ovf_q;
endmodule

// File: rtl/pmc_batch_bank_chk.sv
module pmc_batch_bank_chk #(
  parameter int unsigned NUM_CNT   = 5,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned BATCH_W   = 8,
  parameter int unsigned SEL_W     = 32,
  parameter int unsigned EVT_LSB   = 8,
  parameter int unsigned EVT_W     = 8,
  parameter int unsigned GATED_IDX = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_CNT:0]           en_mask_i,
  input logic                       batch_vld_i,
  input logic [BATCH_W-1:0]         batch_cnt_i,
  input logic                       ovf_en_c1_i,
  input logic                       ovf_en_cx_i,
  input logic [SEL_W-1:0]           evt_sel4_i,
  input logic                       run_latch_i,
  input logic [NUM_CNT:0]           wr_en_i,
  input logic [CNT_W-1:0]           wr_data_i,
  input logic [NUM_CNT*CNT_W-1:0]   cnt_o,
  input logic                       ovf_o
);
  localparam logic [CNT_W-1:0] THRESH = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] c1, cg;
  logic             at_thresh;
  logic             gate_closed;
  logic             unused_chk;

  assign c1          = cnt_o[0 +: CNT_W];
  assign cg          = cnt_o[(GATED_IDX-1)*CNT_W +: CNT_W];
  assign gate_closed = (evt_sel4_i[EVT_LSB +: EVT_W] != EVT_W'('h02)) && !run_latch_i;
  assign unused_chk  = ^{evt_sel4_i, batch_cnt_i, en_mask_i};

  always_comb begin
    at_thresh = 1'b0;
    for (int k = 0; k < NUM_CNT; k++)
      if (cnt_o[k*CNT_W +: CNT_W] == THRESH) at_thresh = 1'b1;
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!batch_vld_i && wr_en_i[NUM_CNT:1] == '0) |=> $stable(cnt_o));

  // R9
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i[1] |=> (c1 == $past(wr_data_i)));

  // R7
  gate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_closed && !wr_en_i[GATED_IDX]) |=> $stable(cg));

  // R2
  c1_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_mask_i[1] && !wr_en_i[1]) |=> $stable(c1));

  // R8
  ovf_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $past(batch_vld_i));

  // R4
  ovf_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> at_thresh);

  // R5
  no_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_en_c1_i && !ovf_en_cx_i) |=> !ovf_o);
endmodule

bind pmc_batch_bank pmc_batch_bank_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_mask_i   (en_mask_i),
  .batch_vld_i (batch_vld_i),
  .batch_cnt_i (batch_cnt_i),
  .ovf_en_c1_i (ovf_en_c1_i),
  .ovf_en_cx_i (ovf_en_cx_i),
  .evt_sel4_i  (evt_sel4_i),
  .run_latch_i (run_latch_i),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .cnt_o       (cnt_o),
  .ovf_o       (ovf_o)
);

// File: tb/tb_pmc_batch_bank.sv
module tb_pmc_batch_bank;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic [5:0]   en_mask_i;
  logic         batch_vld_i;
  logic [7:0]   batch_cnt_i;
  logic         ovf_en_c1_i, ovf_en_cx_i;
  logic [31:0]  evt_sel4_i;
  logic         run_latch_i;
  logic [5:0]   wr_en_i;
  logic [31:0]  wr_data_i;
  logic [159:0] cnt_o;
  logic         ovf_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;
  logic [31:0] exp_c [1:5];
  logic        exp_ovf;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pmc_batch_bank dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_mask_i(en_mask_i),
    .batch_vld_i(batch_vld_i), .batch_cnt_i(batch_cnt_i),
    .ovf_en_c1_i(ovf_en_c1_i), .ovf_en_cx_i(ovf_en_cx_i),
    .evt_sel4_i(evt_sel4_i), .run_latch_i(run_latch_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .cnt_o(cnt_o), .ovf_o(ovf_o)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic compare(string tag);
    for (int k = 1; k <= 5; k++)
      chk(tag, $sformatf("counter%0d", k), cnt_o[(k-1)*32 +: 32], exp_c[k]);
    chk(tag, "ovf_o", {31'b0, ovf_o}, {31'b0, exp_ovf});
  endtask

  // expected state after one edge, from the requirements
  task automatic model();
    logic        o;
    logic [31:0] s;
    logic        oe, allow;
    o = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      allow = (k != 4) || (evt_sel4_i[15:8] == 8'h02) || run_latch_i;
      oe    = (k == 1) ? ovf_en_c1_i : ovf_en_cx_i;
      if (wr_en_i[k]) exp_c[k] = wr_data_i;
      else if (batch_vld_i && en_mask_i[k] && allow) begin
        s = exp_c[k] + {24'b0, batch_cnt_i};
        if (s[31] && oe) begin
          s = 32'h8000_0000;
          o = 1'b1;
        end
        exp_c[k] = s;
      end
    end
    exp_ovf = o;
  endtask

  task automatic step(string tag);
    @(posedge clk_i);
    model();
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic drive(logic [5:0] en, logic vld, logic [7:0] b, logic e1, logic ex,
                       logic [31:0] sel, logic run, logic [5:0] wr, logic [31:0] wd);
    en_mask_i = en; batch_vld_i = vld; batch_cnt_i = b;
    ovf_en_c1_i = e1; ovf_en_cx_i = ex; evt_sel4_i = sel;
    run_latch_i = run; wr_en_i = wr; wr_data_i = wd;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    string tg;
    rst_ni = 1'b0;
    drive(6'h3F, 1'b1, 8'hFF, 1'b1, 1'b1, 32'h0000_0200, 1'b1, 6'h3F, 32'h1234_5678);
    for (int k = 1; k <= 5; k++) exp_c[k] = '0;
    exp_ovf = 1'b0;
    repeat (3) @(negedge clk_i);
    compare("R1");
    drive(6'h00, 1'b0, 8'h00, 1'b0, 1'b0, 32'h0, 1'b1, 6'h00, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1");

    // R2 / R3: full mask sweep, distinct batch sizes
    for (int m = 0; m < 64; m++) begin
      drive(m[5:0], 1'b1, m[7:0] + 8'd1, 1'b0, 1'b0, 32'h0, 1'b1, 6'h00, 32'h0);
      step("R2");
    end
    // R3: no valid, no change
    for (int i = 0; i < 4; i++) begin
      drive(6'h3F, 1'b0, 8'hFF, 1'b1, 1'b1, 32'h0, 1'b1, 6'h00, 32'h0);
      step("R3");
    end

    // R7: counter 4 gate, code field vs run latch; 0x02 in low byte must not open it
    for (int f = 0; f < 8; f++)
      for (int r = 0; r < 2; r++) begin
        drive(6'h3E, 1'b1, 8'd3, 1'b0, 1'b0, {16'hA5A5, f[7:0], 8'h02}, r[0], 6'h00, 32'h0);
        step("R7");
      end

    // R4 / R5 / R6 / R8: preload near threshold under each enable combination
    for (int e = 0; e < 4; e++) begin
      tg = (e == 3) ? "R4" : (e == 0) ? "R6" : "R5";
      foreach (batch_pat[j]) begin
        drive(6'h3E, 1'b0, 8'h00, e[0], e[1], 32'h0, 1'b1, 6'h3E, 32'h7FFF_FF80);
        step("R9");
        drive(6'h3E, 1'b1, batch_pat[j], e[0], e[1], 32'h0, 1'b1, 6'h00, 32'h0);
        step(tg);
        drive(6'h3E, 1'b0, 8'h00, e[0], e[1], 32'h0, 1'b1, 6'h00, 32'h0);
        step("R8");
      end
    end

    // R8: only counter 3 crosses; pulse from a single source
    drive(6'h3E, 1'b0, 8'h00, 1'b1, 1'b1, 32'h0, 1'b1, 6'h3E, 32'h0000_0010);
    step("R9");
    drive(6'h08, 1'b0, 8'h00, 1'b1, 1'b1, 32'h0, 1'b1, 6'h08, 32'h7FFF_FFFE);
    step("R9");
    drive(6'h3E, 1'b1, 8'd2, 1'b1, 1'b1, 32'h0, 1'b1, 6'h00, 32'h0);
    step("R8");
    drive(6'h3E, 1'b1, 8'd1, 1'b1, 1'b1, 32'h0, 1'b1, 6'h00, 32'h0);
    step("R8");

    // R6: wrap past all ones stays unclamped, no pulse
    drive(6'h3E, 1'b0, 8'h00, 1'b1, 1'b1, 32'h0, 1'b1, 6'h3E, 32'hFFFF_FFF0);
    step("R9");
    drive(6'h3E, 1'b1, 8'h20, 1'b1, 1'b1, 32'h0, 1'b1, 6'h00, 32'h0);
    step("R6");

    // R9: load collides with a batch that would clamp
    drive(6'h3F, 1'b1, 8'd5, 1'b1, 1'b1, 32'h0, 1'b1, 6'h3F, 32'h7FFF_FFFF);
    step("R9");
    drive(6'h3E, 1'b1, 8'd5, 1'b1, 1'b1, 32'h0, 1'b1, 6'h07, 32'h0000_0042);
    step("R9");
    drive(6'h3E, 1'b0, 8'd0, 1'b1, 1'b1, 32'h0, 1'b1, 6'h01, 32'hDEAD_BEEF);
    step("R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  logic [7:0] batch_pat [3] = '{8'h7F, 8'h80, 8'hFF};
endmodule